// File: doc/BRIEF.md
# Security Attribution and State Guard

This block sits beside a processor core and answers two questions on every cycle. First, for the address of the current access, it returns the security attribute of the memory region that address falls in: Secure, Non-Secure, or Non-Secure-Callable. Second, it keeps the processor's current security state, reports it, and drives the non-secure qualifier that travels with each bus transfer. Software defines a small table of address windows through a one-cycle write port. Each window has a base, an inclusive limit, an attribute and an enable bit.

The core's decoder reports three kinds of state-switch activity as single-cycle strobes. The first is a branch that hands control to non-secure code. The second is a gateway instruction together with its fetch address. The third is any branch taken together with its target address. The guard moves between the two security states according to fixed rules. Any broken rule is reported as a one-cycle fault with a cause code. Non-secure code can return to secure state only through a gateway instruction that sits in a callable window. The security state is combined with the core's privilege input to report one of four access levels.

Top module: `sec_attr_guard`

## Requirements
- R1: Attribute codes on `acc_attr` are 2'b00 Secure, 2'b01 Non-Secure and 2'b10 Non-Secure-Callable. An enabled window matches addresses from base to limit, both inclusive. A window programmed with code 2'b11 reports Secure. The lookup is combinational, with no clock edge in the path.
- R2: While `rst_n` is low and after its release, `cur_ns`, `bus_nonsec` and `fault` are 0, `fault_cause` is 2'b00, and every window is disabled.
- R3: With `SEC_EN`=1, `bus_nonsec` always equals `cur_ns`: 1 means Non-Secure and 0 means Secure.
- R4: An address that hits no enabled window reads Secure. A disabled window never matches. When enabled windows overlap, the lowest-numbered one supplies the attribute.
- R5: `ev_bxns` in Secure state sets `cur_ns` to 1 at the next rising edge. In Non-Secure state it has no effect and raises no fault.
- R6: `ev_sg` in Non-Secure state with `sg_pc` in a Callable window clears `cur_ns` at the next edge. With `sg_pc` anywhere else, the state stays Non-Secure and a fault with cause 2'b01 is raised. In Secure state, `ev_sg` does nothing.
- R7: `ev_br` in Non-Secure state with `br_target` resolving to Secure raises a fault with cause 2'b10. A target resolving to Non-Secure or Callable raises none. In Secure state, branches are not checked.
- R8: A window write (`cfg_we`) is applied at the next edge only in Secure state. In Non-Secure state the write is dropped and a fault with cause 2'b11 is raised.
- R9: `fault` is registered and high for exactly the cycle after each violating cycle. When it is low, `fault_cause` reads 2'b00. If violations coincide, the cause priority is gateway (01) over branch (10) over write (11).
- R10: `acc_level` equals {`cur_ns`, `acc_priv`}, which gives four access levels.
- R11: With `SEC_EN`=0, `bus_nonsec` and `cur_ns` are held at 1, `fault` stays 0, and window writes are always applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | IW | Window number to write |
| cfg_base | input | AW | Window base address |
| cfg_limit | input | AW | Window inclusive limit address |
| cfg_attr | input | 2 | Window attribute code |
| cfg_en | input | 1 | Window enable |
| acc_addr | input | AW | Address of the current access |
| acc_priv | input | 1 | Privileged access flag |
| acc_attr | output | 2 | Attribute of `acc_addr` |
| acc_level | output | 2 | {non-secure, privileged} level |
| bus_nonsec | output | 1 | Bus non-secure qualifier |
| cur_ns | output | 1 | Current state, 1 = Non-Secure |
| ev_bxns | input | 1 | Branch-to-non-secure strobe |
| ev_sg | input | 1 | Gateway instruction strobe |
| sg_pc | input | AW | Fetch address of the gateway |
| ev_br | input | 1 | Branch taken strobe |
| br_target | input | AW | Branch target address |
| fault | output | 1 | Violation pulse |
| fault_cause | output | 2 | Violation cause code |

## Verification
The hardest event to reach is a legal return to secure state. It needs four things at once: windows programmed while the block is still Secure, a switch to Non-Secure, a Callable window that is still enabled, and a gateway strobe whose fetch address lands inside that window. The stimulus builds this in two ways. Directed steps program overlapping and disabled windows and then walk through each gateway case. The random phase aims half of its gateway fetch addresses at the base of a randomly chosen window, so Callable hits happen often while the block is Non-Secure. A reference model in the bench predicts every state change and fault cause.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    ATTR_S   = 2'b00,
    ATTR_NS  = 2'b01,
    ATTR_NSC = 2'b10,
    ATTR_RSV = 2'b11
  } attr_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_GATE   = 2'b01,
    CAUSE_BRANCH = 2'b10,
    CAUSE_CFG    = 2'b11
  } cause_e;
endpackage

// File: rtl/sag_region_file.sv
module sag_region_file #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_req,
  input  logic                      wr_ok,
  input  logic [IW-1:0]             wr_idx,
  input  logic [AW-1:0]             wr_base,
  input  logic [AW-1:0]             wr_limit,
  input  logic [1:0]                wr_attr,
  input  logic                      wr_en_bit,
  output logic [NREG-1:0][AW-1:0]   base_o,
  output logic [NREG-1:0][AW-1:0]   limit_o,
  output logic [NREG-1:0][1:0]      attr_o,
  output logic [NREG-1:0]           en_o
);
  logic [NREG-1:0][AW-1:0] base_q, base_d;
  logic [NREG-1:0][AW-1:0] limit_q, limit_d;
  logic [NREG-1:0][1:0]    attr_q, attr_d;
  logic [NREG-1:0]         en_q, en_d;
  logic                    wr_fire;

  assign wr_fire = wr_req && wr_ok && (int'(wr_idx) < NREG);

  always_comb begin
    base_d  = base_q;
    limit_d = limit_q;
    attr_d  = attr_q;
    en_d    = en_q;
    if (wr_fire) begin
      base_d[wr_idx]  = wr_base;
      limit_d[wr_idx] = wr_limit;
      attr_d[wr_idx]  = wr_attr;
      en_d[wr_idx]    = wr_en_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      attr_q  <= '0;
      en_q    <= '0;
    end else if (wr_fire) begin
      base_q  <= base_d;
      limit_q <= limit_d;
      attr_q  <= attr_d;
      en_q    <= en_d;
    end
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;
  assign attr_o  = attr_q;
  assign en_o    = en_q;

  // R8: a write refused by the state guard leaves every window untouched
  a_r8_refused_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ok) |=> ($stable(base_q) && $stable(limit_q) && $stable(attr_q) && $stable(en_q)));
endmodule

// File: rtl/sag_lookup.sv
module sag_lookup
  import sag_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]            addr,
  input  logic [NREG-1:0][AW-1:0]  base_i,
  input  logic [NREG-1:0][AW-1:0]  limit_i,
  input  logic [NREG-1:0][1:0]     attr_i,
  input  logic [NREG-1:0]          en_i,
  output attr_e                    attr_o
);
  always_comb begin
    attr_o = ATTR_S;
    // scan downward so the lowest matching index is applied last
    for (int i = NREG - 1; i >= 0; i--) begin
      if (en_i[i] && (addr >= base_i[i]) && (addr <= limit_i[i])) begin
        attr_o = (attr_i[i] == ATTR_RSV) ? ATTR_S : attr_e'(attr_i[i]);
      end
    end
  end
endmodule

// File: rtl/sag_state_ctl.sv
module sag_state_ctl
  import sag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_bxns,
  input  logic   ev_sg,
  input  attr_e  sg_attr,
  input  logic   ev_br,
  input  attr_e  br_attr,
  input  logic   cfg_we,
  output logic   ns_o,
  output logic   fault_o,
  output cause_e cause_o
);
  logic   ns_q, ns_d;
  logic   fault_q, fault_d;
  cause_e cause_q, cause_d;
  logic   gate_ok, gate_bad, br_bad, cfg_bad;

  always_comb begin
    gate_ok  = ns_q && ev_sg && (sg_attr == ATTR_NSC);
    gate_bad = ns_q && ev_sg && (sg_attr != ATTR_NSC);
    br_bad   = ns_q && ev_br && (br_attr != ATTR_NS) && (br_attr != ATTR_NSC);
    cfg_bad  = ns_q && cfg_we;

    ns_d = ns_q;
    if (gate_ok)                ns_d = 1'b0;
    else if (!ns_q && ev_bxns)  ns_d = 1'b1;

    cause_d = CAUSE_NONE;
    if (gate_bad)     cause_d = CAUSE_GATE;
    else if (br_bad)  cause_d = CAUSE_BRANCH;
    else if (cfg_bad) cause_d = CAUSE_CFG;
    fault_d = gate_bad || br_bad || cfg_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q    <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      ns_q    <= ns_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end

  assign ns_o    = ns_q;
  assign fault_o = fault_q;
  assign cause_o = cause_q;

  // R5: a branch to non-secure code from Secure state always lands in Non-Secure
  a_r5_enter_nonsecure: assert property (@(posedge clk) disable iff (!rst_n)
    (!ns_q && ev_bxns) |=> ns_q);

  // R6: the only way out of Non-Secure is a gateway fetched from a callable window
  a_r6_gated_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ns_q) && !ns_q) |-> ($past(ev_sg) && ($past(sg_attr) == ATTR_NSC)));

  // R6: a misplaced gateway faults and keeps the state
  a_r6_bad_gate_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_q && ev_sg && (sg_attr != ATTR_NSC)) |=> (fault_q && (cause_q == CAUSE_GATE) && ns_q));

  // R7: a secure target reached from Non-Secure is reported as a branch fault
  a_r7_branch_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_q && ev_br && (br_attr == ATTR_S) && !(ev_sg && (sg_attr != ATTR_NSC)))
      |=> (fault_q && (cause_q == CAUSE_BRANCH)));

  // R9: a cycle with no event never produces a fault
  a_r9_quiet_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_sg && !ev_br && !cfg_we) |=> (!fault_q && (cause_q == CAUSE_NONE)));
endmodule

// File: rtl/sec_attr_guard.sv
module sec_attr_guard
  import sag_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int AW     = 32,
  parameter bit SEC_EN = 1'b1,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic [1:0]    cfg_attr,
  input  logic          cfg_en,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_priv,
  output logic [1:0]    acc_attr,
  output logic [1:0]    acc_level,
  output logic          bus_nonsec,
  output logic          cur_ns,
  input  logic          ev_bxns,
  input  logic          ev_sg,
  input  logic [AW-1:0] sg_pc,
  input  logic          ev_br,
  input  logic [AW-1:0] br_target,
  output logic          fault,
  output logic [1:0]    fault_cause
);
  localparam int NLU = 3;

  logic [NREG-1:0][AW-1:0] rg_base, rg_limit;
  logic [NREG-1:0][1:0]    rg_attr;
  logic [NREG-1:0]         rg_en;
  logic [AW-1:0]           lu_addr [NLU];
  attr_e                   lu_attr [NLU];
  logic                    ns_state;
  logic                    wr_allowed;

  assign lu_addr[0] = acc_addr;
  assign lu_addr[1] = sg_pc;
  assign lu_addr[2] = br_target;

  sag_region_file #(.NREG(NREG), .AW(AW)) u_regions (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (cfg_we),
    .wr_ok     (wr_allowed),
    .wr_idx    (cfg_idx),
    .wr_base   (cfg_base),
    .wr_limit  (cfg_limit),
    .wr_attr   (cfg_attr),
    .wr_en_bit (cfg_en),
    .base_o    (rg_base),
    .limit_o   (rg_limit),
    .attr_o    (rg_attr),
    .en_o      (rg_en)
  );

  for (genvar g = 0; g < NLU; g++) begin : g_lu
    sag_lookup #(.NREG(NREG), .AW(AW)) u_lu (
      .addr    (lu_addr[g]),
      .base_i  (rg_base),
      .limit_i (rg_limit),
      .attr_i  (rg_attr),
      .en_i    (rg_en),
      .attr_o  (lu_attr[g])
    );
  end

  if (SEC_EN) begin : g_sec
    cause_e cause_w;
    sag_state_ctl u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_bxns (ev_bxns),
      .ev_sg   (ev_sg),
      .sg_attr (lu_attr[1]),
      .ev_br   (ev_br),
      .br_attr (lu_attr[2]),
      .cfg_we  (cfg_we),
      .ns_o    (ns_state),
      .fault_o (fault),
      .cause_o (cause_w)
    );
    assign fault_cause = cause_w;
    assign wr_allowed  = !ns_state;
  end else begin : g_nosec
    assign ns_state    = 1'b1;
    assign fault       = 1'b0;
    assign fault_cause = CAUSE_NONE;
    assign wr_allowed  = 1'b1;
  end

  assign cur_ns     = ns_state;
  assign bus_nonsec = ns_state;
  assign acc_attr   = lu_attr[0];
  assign acc_level  = {ns_state, acc_priv};

  // R3: the bus qualifier follows the tracked state on every cycle
  a_r3_bus_tracks_state: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nonsec == cur_ns);
endmodule

// File: tb/sec_attr_guard_test.sv
module sec_attr_guard_test;
  localparam int NREG = 8;
  localparam int AW   = 32;
  localparam int IW   = 3;

  logic          clk;
  logic          rst_n;
  logic          cfg_we, cfg_en, acc_priv, ev_bxns, ev_sg, ev_br;
  logic [IW-1:0] cfg_idx;
  logic [AW-1:0] cfg_base, cfg_limit, acc_addr, sg_pc, br_target;
  logic [1:0]    cfg_attr;
  logic [1:0]    acc_attr, acc_level, fault_cause;
  logic          bus_nonsec, cur_ns, fault;
  logic [1:0]    acc_attr_off, acc_level_off, fault_cause_off;
  logic          bus_nonsec_off, cur_ns_off, fault_off;

  int total = 0;
  int bad   = 0;

  // reference model
  logic [AW-1:0] m_base [NREG];
  logic [AW-1:0] m_lim  [NREG];
  logic [1:0]    m_attr [NREG];
  logic          m_en   [NREG];
  logic          m_ns;
  logic          m_fault;
  logic [1:0]    m_cause;

  sec_attr_guard #(.NREG(NREG), .AW(AW), .SEC_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_attr(cfg_attr), .cfg_en(cfg_en),
    .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_attr(acc_attr), .acc_level(acc_level),
    .bus_nonsec(bus_nonsec), .cur_ns(cur_ns), .ev_bxns(ev_bxns), .ev_sg(ev_sg),
    .sg_pc(sg_pc), .ev_br(ev_br), .br_target(br_target), .fault(fault),
    .fault_cause(fault_cause)
  );

  sec_attr_guard #(.NREG(NREG), .AW(AW), .SEC_EN(1'b0)) uut_off (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_attr(cfg_attr), .cfg_en(cfg_en),
    .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_attr(acc_attr_off), .acc_level(acc_level_off),
    .bus_nonsec(bus_nonsec_off), .cur_ns(cur_ns_off), .ev_bxns(ev_bxns), .ev_sg(ev_sg),
    .sg_pc(sg_pc), .ev_br(ev_br), .br_target(br_target), .fault(fault_off),
    .fault_cause(fault_cause_off)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] m_look(input logic [AW-1:0] a);
    logic [1:0] r;
    r = 2'b00;
    for (int i = NREG - 1; i >= 0; i--)
      if (m_en[i] && a >= m_base[i] && a <= m_lim[i])
        r = (m_attr[i] == 2'b11) ? 2'b00 : m_attr[i];
    return r;
  endfunction

  task automatic idle_inputs();
    cfg_we = 0; cfg_idx = '0; cfg_base = '0; cfg_limit = '0; cfg_attr = '0; cfg_en = 0;
    ev_bxns = 0; ev_sg = 0; sg_pc = '0; ev_br = 0; br_target = '0;
  endtask

  // inputs already driven after a falling edge; check, clock, check again
  task automatic step();
    logic c1, c2, c3, old_ns;
    #1;
    chk("R1 comb attr", acc_attr, m_look(acc_addr));
    chk("R10 level", acc_level, {m_ns, acc_priv});
    chk("R11 off level", acc_level_off, {1'b1, acc_priv});
    old_ns = m_ns;
    c1 = m_ns && ev_sg && (m_look(sg_pc) != 2'b10);
    c2 = m_ns && ev_br && (m_look(br_target) == 2'b00);
    c3 = m_ns && cfg_we;
    m_cause = c1 ? 2'b01 : c2 ? 2'b10 : c3 ? 2'b11 : 2'b00;
    m_fault = c1 | c2 | c3;
    if (m_ns && ev_sg && m_look(sg_pc) == 2'b10) m_ns = 1'b0;
    else if (!m_ns && ev_bxns) m_ns = 1'b1;
    if (cfg_we && !old_ns) begin
      m_base[cfg_idx] = cfg_base; m_lim[cfg_idx] = cfg_limit;
      m_attr[cfg_idx] = cfg_attr; m_en[cfg_idx] = cfg_en;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R5 state", cur_ns, m_ns);
    chk("R3 bus qual", bus_nonsec, m_ns);
    chk("R9 fault", fault, m_fault);
    chk("R9 cause", fault_cause, m_cause);
    chk("R11 off state", {bus_nonsec_off, cur_ns_off, fault_off}, 3'b110);
    idle_inputs();
  endtask

  task automatic wr(input int idx, input int b, input int l, input logic [1:0] at, input logic en);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_base = b; cfg_limit = l; cfg_attr = at; cfg_en = en;
    step();
  endtask

  task automatic look(input int a, input logic [1:0] exp, input string tag);
    acc_addr = a;
    #1;
    chk(tag, acc_attr, exp);
  endtask

  initial begin
    rst_n = 0; acc_addr = '0; acc_priv = 0;
    idle_inputs();
    for (int i = 0; i < NREG; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_attr[i] = '0; m_en[i] = 0;
    end
    m_ns = 0; m_fault = 0; m_cause = 0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R2 reset ns", cur_ns, 0);
    chk("R2 reset fault", {fault, fault_cause}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    chk("R2 after release ns", cur_ns, 0);
    chk("R2 after release bus", bus_nonsec, 0);
    look(50, 2'b00, "R2 windows cleared");

    // program windows while Secure
    wr(0, 10, 20, 2'b01, 1);
    wr(1, 15, 40, 2'b10, 1);
    wr(2, 60, 70, 2'b11, 1);
    wr(3, 80, 90, 2'b00, 1);
    wr(4, 100, 120, 2'b10, 0);
    look(10, 2'b01, "R1 base inclusive");
    look(20, 2'b01, "R1 limit inclusive");
    look(21, 2'b10, "R1 callable");
    look(15, 2'b01, "R4 overlap lowest wins");
    look(41, 2'b00, "R4 miss secure");
    look(65, 2'b00, "R1 code 11 reads secure");
    look(110, 2'b00, "R4 disabled window");
    acc_priv = 1; #1;
    chk("R10 secure privileged", acc_level, 2'b01);

    ev_sg = 1; sg_pc = 12; step();
    chk("R6 gateway in secure no fault", {cur_ns, fault}, 2'b00);
    ev_br = 1; br_target = 85; step();
    chk("R7 secure branch unchecked", fault, 0);
    ev_bxns = 1; step();
    chk("R5 enter nonsecure", cur_ns, 1);
    acc_priv = 0; #1;
    chk("R10 nonsecure unprivileged", acc_level, 2'b10);
    ev_bxns = 1; step();
    chk("R5 second bxns no effect", {cur_ns, fault}, 2'b10);
    wr(0, 200, 210, 2'b10, 1);
    chk("R8 ns write fault", {fault, fault_cause}, 3'b111);
    look(10, 2'b01, "R8 write ignored");
    ev_br = 1; br_target = 85; step();
    chk("R7 secure target", {fault, fault_cause}, 3'b110);
    ev_br = 1; br_target = 65; step();
    chk("R7 code11 target", {fault, fault_cause}, 3'b110);
    ev_br = 1; br_target = 50; step();
    chk("R7 default target", {fault, fault_cause}, 3'b110);
    ev_br = 1; br_target = 12; step();
    chk("R7 ns target ok", fault, 0);
    ev_br = 1; br_target = 30; step();
    chk("R7 nsc target ok", fault, 0);
    ev_sg = 1; sg_pc = 12; step();
    chk("R6 bad gateway", {cur_ns, fault, fault_cause}, 4'b1101);
    ev_sg = 1; sg_pc = 110; ev_br = 1; br_target = 85; cfg_we = 1; cfg_idx = 1; cfg_en = 0;
    step();
    chk("R9 priority gateway", {fault, fault_cause}, 3'b101);
    look(30, 2'b10, "R8 combined write ignored");
    step();
    chk("R9 single pulse", {fault, fault_cause}, 3'b000);
    ev_sg = 1; sg_pc = 30; step();
    chk("R6 legal gateway", {cur_ns, fault}, 2'b00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom % 10;
      acc_addr = $urandom % 256;
      acc_priv = $urandom % 2;
      if (r < 2) begin
        int b;
        b = $urandom % 256;
        cfg_we = 1; cfg_idx = IW'($urandom % NREG); cfg_base = b;
        cfg_limit = b + ($urandom % 48); cfg_attr = 2'($urandom % 4); cfg_en = ($urandom % 4) != 0;
      end else if (r < 4) begin
        ev_bxns = 1;
      end else if (r < 6) begin
        ev_sg = 1;
        sg_pc = ($urandom % 2) ? m_base[$urandom % NREG] : ($urandom % 256);
      end else if (r < 8) begin
        ev_br = 1; br_target = $urandom % 256;
      end else if (r == 8) begin
        ev_sg = $urandom % 2; sg_pc = $urandom % 256;
        ev_br = $urandom % 2; br_target = $urandom % 256;
        cfg_we = $urandom % 2; cfg_idx = IW'($urandom % NREG);
        cfg_base = $urandom % 256; cfg_limit = 255; cfg_attr = 2'($urandom % 4); cfg_en = 1;
      end
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule